// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the low-order address bits for a four-beat memory burst. A burst begins when either of two active-low address strobes is sampled low at a rising clock edge. The two low bits presented with the strobe are captured as the start value, and the beat count returns to zero. On later edges the beat count moves forward by one while the active-low advance input is low, and it holds while advance is high.

A static order input selects how the beat count is combined with the start value. In linear order the output is the start value plus the count, taken modulo four. In interleaved order the output is the start value XOR the count. A flag marks the fourth beat of the sequence. If advance stays low, the count wraps and the same four addresses repeat. Upper address bits, the storage array and the data path belong to neighbouring logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronised reset is active, and at the first check after it is released, `beat_bits` is 0 and `last_beat` is 0.
- R2: When `strobe_a_n` or `strobe_b_n` is low at a rising edge, the start value is taken from `start_bits` and the beat count is cleared. After that edge `beat_bits` equals the loaded start value and `last_beat` is 0.
- R3: When both strobes are high and `advance_n` is low at a rising edge, the beat count increases by one.
- R4: When both strobes and `advance_n` are high at a rising edge, the beat count and `beat_bits` are unchanged.
- R5: With `order_sel` = 0 (linear), `beat_bits` = (start + count) mod 4.
- R6: With `order_sel` = 1 (interleaved), `beat_bits` = start XOR count.
- R7: After the fourth beat (count 3), another advance returns the count to 0, and the same four-address sequence repeats.
- R8: A strobe sampled low in the same cycle as `advance_n` low causes a load and no step.
- R9: `last_beat` is 1 exactly when the beat count is 3.
- R10: When both strobes are low together, the block loads exactly as it does for a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strobe_a_n | input | 1 | First active-low address strobe |
| strobe_b_n | input | 1 | Second active-low address strobe |
| start_bits | input | 2 | Low address bits that are loaded as the start value |
| advance_n | input | 1 | Active-low step request |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| beat_bits | output | 2 | Current low address bits |
| last_beat | output | 1 | High on the fourth beat |

## Verification
Every start value from 0 to 3 is loaded in both orders and then advanced through a full burst and beyond it. Linear and interleaved output differ for starts 1 and 3, so these sweeps show which mapping is applied, and the extra beat shows the wrap. Runs that mix hold cycles with advance cycles separate a count that steps on every edge from one that respects `advance_n`. Cycles that assert a strobe together with advance, and cycles that assert both strobes, confirm the load priority and that either strobe source is accepted.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned BEAT_W = burst_seq_pkg::BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic [BEAT_W-1:0] start_in,
  output logic              load,
  output logic [BEAT_W-1:0] start_q
);
  logic [BEAT_W-1:0] start_d;

  always_comb begin
    load    = !strobe_a_n || !strobe_b_n;
    start_d = start_q;
    if (load) start_d = start_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    start_q <= '0;
    else if (load) start_q <= start_d;
  end

  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> start_q == $past(start_in));
  // R4
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(start_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = burst_seq_pkg::BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || step;
    cnt_d  = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2 / R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == '0);
  // R3 / R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> cnt_q == $past(cnt_q) + ONE);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int unsigned BEAT_W = burst_seq_pkg::BEAT_W
) (
  input  burst_seq_pkg::burst_order_e order,
  input  logic [BEAT_W-1:0]           start_q,
  input  logic [BEAT_W-1:0]           cnt_q,
  output logic [BEAT_W-1:0]           addr_bits
);
  logic [BEAT_W-1:0] lin_bits;
  logic [BEAT_W-1:0] xor_bits;

  assign lin_bits = start_q + cnt_q;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_bits[b] = start_q[b] ^ cnt_q[b];
  end

  always_comb begin
    addr_bits = lin_bits;
    if (order == burst_seq_pkg::ORDER_XOR) addr_bits = xor_bits;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned BEAT_W = burst_seq_pkg::BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a_n,
  input  logic              strobe_b_n,
  input  logic [BEAT_W-1:0] start_bits,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [BEAT_W-1:0] beat_bits,
  output logic              last_beat
);
  logic              rst_sync_n;
  logic              load;
  logic              step;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt_q;
  burst_seq_pkg::burst_order_e order;

  assign step  = !advance_n;
  assign order = burst_seq_pkg::burst_order_e'(order_sel);

  burst_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  burst_start_reg #(.BEAT_W(BEAT_W)) i_start (
    .clk(clk), .rst_n(rst_sync_n), .strobe_a_n(strobe_a_n),
    .strobe_b_n(strobe_b_n), .start_in(start_bits),
    .load(load), .start_q(start_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .step(step), .cnt_q(cnt_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) i_map (
    .order(order), .start_q(start_q), .cnt_q(cnt_q), .addr_bits(beat_bits)
  );

  assign last_beat = &cnt_q;

  // R2 / R10: first beat after any load is the captured start value
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && $stable(order_sel)) |=> (beat_bits == $past(start_bits) && !last_beat));
  // R9
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_beat && !load && step) |=> !last_beat);
  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (beat_bits == '0 && !last_beat));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_a_n = 1'b1;
  logic       strobe_b_n = 1'b1;
  logic [1:0] start_bits = 2'd0;
  logic       advance_n = 1'b1;
  logic       order_sel = 1'b0;
  logic [1:0] beat_bits;
  logic       last_beat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] beat;
    logic       last;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  logic [1:0] m_start = 2'd0;
  logic [1:0] m_k = 2'd0;

  always #5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .strobe_a_n(strobe_a_n), .strobe_b_n(strobe_b_n),
    .start_bits(start_bits), .advance_n(advance_n), .order_sel(order_sel),
    .beat_bits(beat_bits), .last_beat(last_beat)
  );

  task automatic check(input logic [1:0] ab, input logic al,
                       input logic [1:0] eb, input logic el, input string tag);
    checks++;
    if (ab !== eb || al !== el) begin
      fails++;
      $display("FAIL %s: beat_bits=%0d last_beat=%0b expected beat_bits=%0d last_beat=%0b",
               tag, ab, al, eb, el);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: one clock cycle of stimulus, expected result pushed to scoreboard
  task automatic drive(input logic sa, input logic sb, input logic adv,
                       input logic [1:0] st, input logic mode, input string tag);
    exp_t e;
    @(negedge clk);
    strobe_a_n = sa; strobe_b_n = sb; advance_n = adv;
    start_bits = st; order_sel = mode;
    @(posedge clk);
    if (!sa || !sb) begin
      m_start = st; m_k = 2'd0;
    end else if (!adv) begin
      m_k = m_k + 2'd1;
    end
    e.beat = mode ? (m_start ^ m_k) : (m_start + m_k);
    e.last = (m_k == 2'd3);
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pop and compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(beat_bits, last_beat, e.beat, e.last, e.tag);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(beat_bits, last_beat, 2'd0, 1'b0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(beat_bits, last_beat, 2'd0, 1'b0, "R1 after reset");

    // linear, strobe A, start 1: load, 5 advances (wrap), then holds
    drive(1'b0, 1'b1, 1'b1, 2'd1, 1'b0, "R2 load strobe_a");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R3 R5 R7 R9 linear step");
    drive(1'b1, 1'b1, 1'b1, 2'd2, 1'b0, "R4 hold");
    drive(1'b1, 1'b1, 1'b1, 2'd3, 1'b0, "R4 hold");

    // interleaved, strobe B, start 2
    drive(1'b1, 1'b0, 1'b1, 2'd2, 1'b1, "R2 load strobe_b");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R6 R7 R9 interleaved step");

    // mixed holds and steps, interleaved start 3
    drive(1'b0, 1'b1, 1'b1, 2'd3, 1'b1, "R2 load");
    drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R3 R6 step");
    drive(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, "R4 hold");
    drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R3 R6 step");
    drive(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, "R4 hold");
    drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R9 step to last");

    // strobe with advance: load wins
    drive(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, "R8 strobe_a over advance");
    drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R3 step");
    drive(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, "R8 strobe_b over advance");

    // both strobes together
    drive(1'b0, 1'b0, 1'b1, 2'd3, 1'b0, "R10 both strobes");
    drive(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R5 step after dual load");

    // full sweep of starts in both orders
    for (int mode = 0; mode < 2; mode++) begin
      for (int s = 0; s < 4; s++) begin
        drive(1'b0, 1'b1, 1'b1, 2'(s), 1'(mode), "R2 sweep load");
        for (int k = 0; k < 5; k++)
          drive(1'b1, 1'b1, 1'b0, 2'd0, 1'(mode), mode ? "R6 R7 sweep" : "R5 R7 sweep");
      end
    end

    @(posedge clk);
    #2;
    done = 1'b1;
    summary();
  end
endmodule